// File: doc/BRIEF.md
# Multi-Format Serial Audio Deserializer

This block takes a stereo audio stream carried on three wires: a bit clock, a word clock that marks each half of a stereo frame, and one serial data line. It converts the stream into a pair of parallel 24-bit samples, one for channel A (left) and one for channel B (right). The block is clocked directly by the bit clock. On each rising edge it samples the data line and the word clock, and it finds word-clock transitions by comparing the word clock with its value one edge earlier.

A 3-bit format code selects one of five framings. Left-justified framing puts the sample at the start of each half-frame. Right-justified framing puts it at the end. I2S framing delays the sample by one bit-clock period after the transition. Left-justified and right-justified framing can each send the sample MSB first or LSB first. The code is taken only while reset is held, so the framing stays fixed for the whole run.

When both channels of a frame have been recovered, the block presents the two samples together and raises a valid strobe for one cycle.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `chan_a` and `chan_b` are zero and `frame_valid` is low until the first completed frame.
- R2: Format code 0 (left-justified, MSB first): the bit sampled on the edge that detects a word-clock transition is sample bit 23, and the next 23 edges give bits 22 down to 0.
- R3: Format code 1 (left-justified) and code 3 (right-justified) receive the sample LSB first: bit 0 arrives first and bit 23 arrives last.
- R4: Format code 2 (right-justified, MSB first): the sample is the last 24 bits sampled before the next word-clock transition. Any earlier bits in that half-frame are ignored.
- R5: Format code 4 (I2S): bit 23 is sampled one bit-clock period after the edge that detects the transition, and the sample is sent MSB first. Channel A is the half with the word clock low. In all other formats channel A is the half with the word clock high.
- R6: In left-justified and I2S framing, any bits after the 24 sample bits of a half-frame have no effect on the recovered samples.
- R7: `frame_valid` is high for exactly one cycle per frame, after channel B has been captured following channel A. `chan_a` and `chan_b` change only together with that strobe. In left-justified MSB-first mode with 32-bit halves, the strobe is high during the cycle after the edge that samples channel B's 24th bit.
- R8: A half-frame too short to hold a whole sample is not captured. A frame with such a half produces no strobe: the minimum is 24 bits for left-justified and right-justified framing and 25 bits for I2S.
- R9: `fmt_sel` is sampled only while `rst_n` is low, and changes afterwards have no effect. Codes 5, 6 and 7 behave as code 0.
- R10: Nothing is captured from a half-frame that did not start at a word-clock transition seen after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; data and word clock are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; format code is taken while low |
| fmt_sel | input | 3 | Format code (0 LJ-MSB, 1 LJ-LSB, 2 RJ-MSB, 3 RJ-LSB, 4 I2S) |
| word_clk | input | 1 | Word clock marking channel halves |
| ser_data | input | 1 | Serial audio data |
| chan_a | output | SAMPLE_W | Recovered channel A sample |
| chan_b | output | SAMPLE_W | Recovered channel B sample |
| frame_valid | output | 1 | One-cycle strobe when a stereo pair is presented |

## Verification
Each of the five format codes is driven with asymmetric sample values and unused bit periods filled with ones. This separates bit-order errors, off-by-one alignment errors and leakage of filler bits into a sample. Streams whose half-frames are exactly the minimum length, or one bit too short, test the capture window boundary for each alignment. Streams that begin without a transition test the start-up condition, and a format code changed after reset tests that the code is ignored outside reset. One directed stream fixes the exact cycle of the strobe.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    ALIGN_LEFT   = 2'd0,
    ALIGN_RIGHT  = 2'd1,
    ALIGN_DELAY1 = 2'd2
  } align_e;

  typedef struct packed {
    align_e align;
    logic   lsb_first;
    logic   a_level;    // word-clock level of the channel A half
  } fmt_cfg_t;

  // Format code decode; unknown codes fall back to left-justified MSB first.
  function automatic fmt_cfg_t decode_fmt(input logic [2:0] code);
    fmt_cfg_t c;
    case (code)
      3'd1:    c = '{align: ALIGN_LEFT,   lsb_first: 1'b1, a_level: 1'b1};
      3'd2:    c = '{align: ALIGN_RIGHT,  lsb_first: 1'b0, a_level: 1'b1};
      3'd3:    c = '{align: ALIGN_RIGHT,  lsb_first: 1'b1, a_level: 1'b1};
      3'd4:    c = '{align: ALIGN_DELAY1, lsb_first: 1'b0, a_level: 1'b0};
      default: c = '{align: ALIGN_LEFT,   lsb_first: 1'b0, a_level: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sad_fmt_latch.sv
module sad_fmt_latch
  import sad_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     fmt_sel,
  output logic [2:0]     fmt_q,
  output fmt_cfg_t       cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) fmt_q <= fmt_sel;
  end

  assign cfg = decode_fmt(fmt_q);

endmodule

// File: rtl/sad_half_tracker.sv
module sad_half_tracker #(
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_clk,
  output logic             wc_edge,
  output logic             wc_prev,
  output logic [POS_W-1:0] pos_cur,
  output logic [POS_W-1:0] bits_prev,
  output logic             synced_r
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             wc_d;
  logic [POS_W-1:0] pos_r;

  assign wc_edge   = word_clk ^ wc_d;
  assign wc_prev   = wc_d;
  assign pos_cur   = wc_edge ? '0 : pos_r;
  assign bits_prev = pos_r;   // bit count of the half just ended, valid on an edge

  always_ff @(posedge clk) begin
    wc_d <= word_clk;
    if (!rst_n) begin
      pos_r    <= '0;
      synced_r <= 1'b0;
    end else begin
      pos_r <= (pos_cur == POS_MAX) ? POS_MAX : pos_cur + 1'b1;
      if (wc_edge) synced_r <= 1'b1;
    end
  end

endmodule

// File: rtl/sad_shifter.sv
module sad_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  input  logic         lsb_first,
  output logic [W-1:0] sr_q,
  output logic [W-1:0] sr_next
);

  function automatic logic [W-1:0] push_bit(input logic [W-1:0] v,
                                            input logic b, input logic lsb);
    return lsb ? {b, v[W-1:1]} : {v[W-2:0], b};
  endfunction

  assign sr_next = push_bit(sr_q, din, lsb_first);

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_next;
  end

endmodule

// File: rtl/sad_pair.sv
module sad_pair #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_a_ev,
  input  logic         cap_b_ev,
  input  logic [W-1:0] sample,
  output logic [W-1:0] chan_a,
  output logic [W-1:0] chan_b,
  output logic         frame_valid
);

  logic [W-1:0] a_hold;
  logic         a_have;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_hold      <= '0;
      a_have      <= 1'b0;
      chan_a      <= '0;
      chan_b      <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (cap_a_ev) begin
        a_hold <= sample;
        a_have <= 1'b1;
      end else if (cap_b_ev && a_have) begin
        chan_a      <= a_hold;
        chan_b      <= sample;
        frame_valid <= 1'b1;
        a_have      <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sad_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int POS_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          fmt_sel,
  input  logic                word_clk,
  input  logic                ser_data,
  output logic [SAMPLE_W-1:0] chan_a,
  output logic [SAMPLE_W-1:0] chan_b,
  output logic                frame_valid
);

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SAMPLE_W - 1);
  localparam logic [POS_W-1:0] POS_DLY  = POS_W'(SAMPLE_W);

  logic [2:0]          fmt_q;
  fmt_cfg_t            cfg;
  logic                wc_edge, wc_prev, synced_r;
  logic [POS_W-1:0]    pos_cur, bits_prev;
  logic [SAMPLE_W-1:0] sr_q, sr_next, sample;
  logic                cap_ev, cap_level, is_a;
  logic                cap_a_ev, cap_b_ev;

  sad_fmt_latch u_fmt (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .fmt_q(fmt_q), .cfg(cfg)
  );

  sad_half_tracker #(.POS_W(POS_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .word_clk(word_clk),
    .wc_edge(wc_edge), .wc_prev(wc_prev), .pos_cur(pos_cur),
    .bits_prev(bits_prev), .synced_r(synced_r)
  );

  sad_shifter #(.W(SAMPLE_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .din(ser_data), .lsb_first(cfg.lsb_first),
    .sr_q(sr_q), .sr_next(sr_next)
  );

  // Capture point selection per alignment
  always_comb begin
    cap_ev    = 1'b0;
    cap_level = word_clk;
    sample    = sr_next;
    case (cfg.align)
      ALIGN_RIGHT: begin
        // the half that just ended must have started at a seen transition
        cap_ev    = wc_edge && synced_r && (bits_prev >= POS_DLY);
        cap_level = wc_prev;
        sample    = sr_q;
      end
      ALIGN_DELAY1: cap_ev = (synced_r || wc_edge) && (pos_cur == POS_DLY);
      default:      cap_ev = (synced_r || wc_edge) && (pos_cur == POS_LAST);
    endcase
  end

  assign is_a     = (cap_level == cfg.a_level);
  assign cap_a_ev = cap_ev && is_a && rst_n;
  assign cap_b_ev = cap_ev && !is_a && rst_n;

  sad_pair #(.W(SAMPLE_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .cap_a_ev(cap_a_ev), .cap_b_ev(cap_b_ev),
    .sample(sample), .chan_a(chan_a), .chan_b(chan_b),
    .frame_valid(frame_valid)
  );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_valid,
  input logic [SAMPLE_W-1:0] chan_a,
  input logic [SAMPLE_W-1:0] chan_b,
  input logic                cap_a_ev,
  input logic                cap_b_ev,
  input logic                synced_r,
  input logic [2:0]          fmt_q
);

  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> ($stable(chan_a) && $stable(chan_b)));

  a_r7_after_b: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(cap_b_ev));

  a_r9_fmt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(fmt_q));

  a_r10_no_capture_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_r |-> (!cap_a_ev && !cap_b_ev));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_a_ev && cap_b_ev));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
  .chan_a(chan_a), .chan_b(chan_b), .cap_a_ev(cap_a_ev),
  .cap_b_ev(cap_b_ev), .synced_r(synced_r), .fmt_q(fmt_q)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        word_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic [23:0] chan_a, chan_b;
  logic        frame_valid;

  int nchk = 0;
  int nerr = 0;
  int nv   = 0;
  logic [23:0] ga [256];
  logic [23:0] gb [256];

  always #4 clk = ~clk;   // 125 MHz

  serial_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .word_clk(word_clk),
    .ser_data(ser_data), .chan_a(chan_a), .chan_b(chan_b),
    .frame_valid(frame_valid)
  );

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      ga[nv[7:0]] = chan_a;
      gb[nv[7:0]] = chan_b;
      nv++;
    end
  end

  // fields: fmt[56:54] len[53:48] a[47:24] b[23:0]
  localparam logic [56:0] VEC [10] = '{
    {3'd0, 6'd32, 24'h123456, 24'hABCDEF},
    {3'd1, 6'd32, 24'h5A0F33, 24'hC3A501},
    {3'd2, 6'd32, 24'h800001, 24'h7FFFFE},
    {3'd3, 6'd32, 24'h0F1E2D, 24'hF0E1D2},
    {3'd4, 6'd32, 24'hA5A5A5, 24'h3C3C3C},
    {3'd0, 6'd24, 24'hFEDCBA, 24'h012345},
    {3'd2, 6'd24, 24'h13579B, 24'h2468AC},
    {3'd4, 6'd25, 24'hC00003, 24'h5AA55A},
    {3'd6, 6'd32, 24'hDEAD12, 24'hBEEF34},
    {3'd3, 6'd48, 24'h010203, 24'hA0B0C0}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [47:0] act, input logic [47:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit on the data line at position k of a half of length len.
  // Unused positions carry ones (R6 filler).
  function automatic logic bit_at(input int f, input logic [23:0] s,
                                  input int k, input int len);
    int st;
    st = len - 24;
    case (f)
      0: return (k < 24) ? s[23-k] : 1'b1;
      1: return (k < 24) ? s[k] : 1'b1;
      2: return (k >= st) ? s[23-(k-st)] : 1'b1;
      3: return (k >= st) ? s[k-st] : 1'b1;
      default: return (k >= 1 && k <= 24) ? s[24-k] : 1'b1;
    endcase
  endfunction

  task automatic do_reset(input logic [2:0] code, input logic lvl);
    @(negedge clk);
    rst_n = 1'b0; fmt_sel = code; word_clk = lvl; ser_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // chk_at >= 0: strobe must be low at position chk_at-1 and high at chk_at
  task automatic half(input logic lvl, input int f, input logic [23:0] s,
                      input int len, input int chk_at);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k == chk_at - 1)
        chk(frame_valid == 1'b0, "R7 strobe early", {47'd0, frame_valid}, 48'd0);
      if (k == chk_at)
        chk(frame_valid == 1'b1, "R7 strobe timing", {47'd0, frame_valid}, 48'd1);
      word_clk = lvl;
      ser_data = bit_at(f, s, k, len);
    end
  endtask

  task automatic run_stream(input int f, input int len_a, input int len_b,
                            input logic [23:0] a, input logic [23:0] b,
                            input int chk_b);
    logic alev;
    alev = (f == 4) ? 1'b0 : 1'b1;
    half(!alev, f, 24'h0, len_a, -1);
    half(alev, f, a, len_a, -1);
    half(!alev, f, b, len_b, chk_b);
    half(alev, f, ~a, len_a, -1);
    half(!alev, f, ~b, len_b, -1);
    half(alev, f, 24'h0, len_a, -1);
    repeat (4) @(negedge clk);
  endtask

  function automatic string tag_of(input int f);
    case (f)
      1, 3: return "R3";
      2:    return "R4";
      4:    return "R5";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int base;
    // R1: reset state
    do_reset(3'd0, 1'b0);
    @(negedge clk);
    chk(frame_valid == 1'b0, "R1 valid", {47'd0, frame_valid}, 48'd0);
    chk(chan_a == 24'd0 && chan_b == 24'd0, "R1 samples", {chan_a, chan_b}, 48'd0);

    // Vector walk: every format, filler ones in unused periods (R6)
    for (int i = 0; i < 10; i++) begin
      int f, code, len;
      logic [23:0] a, b;
      string t;
      code = int'(VEC[i][56:54]);
      len  = int'(VEC[i][53:48]);
      a    = VEC[i][47:24];
      b    = VEC[i][23:0];
      f    = (code > 4) ? 0 : code;   // R9: codes 5..7 act as code 0
      t    = (code > 4) ? "R9" : tag_of(f);
      do_reset(3'(code), (f == 4) ? 1'b1 : 1'b0);
      base = nv;
      run_stream(f, len, len, a, b, -1);
      chk(nv - base == 2, {t, " count"}, 48'(nv - base), 48'd2);
      chk(ga[base[7:0]] == a && gb[base[7:0]] == b, {t, " frame0 R6"},
          {ga[base[7:0]], gb[base[7:0]]}, {a, b});
      chk(ga[8'(base+1)] == ~a && gb[8'(base+1)] == ~b, {t, " frame1"},
          {ga[8'(base+1)], gb[8'(base+1)]}, {~a, ~b});
    end

    // R7: strobe cycle, LJ MSB first, 32-bit halves
    do_reset(3'd0, 1'b0);
    base = nv;
    run_stream(0, 32, 32, 24'h6B1C2D, 24'h93E4F5, 24);
    chk(nv - base == 2, "R7 count", 48'(nv - base), 48'd2);

    // R9: format change after reset is ignored (stream stays LJ MSB)
    do_reset(3'd0, 1'b0);
    fmt_sel = 3'd4;
    base = nv;
    run_stream(0, 32, 32, 24'h314159, 24'h265358, -1);
    chk(nv - base == 2 && ga[base[7:0]] == 24'h314159 && gb[base[7:0]] == 24'h265358,
        "R9 late change", {ga[base[7:0]], gb[base[7:0]]}, {24'h314159, 24'h265358});

    // R8: LJ halves of 23 bits never capture
    do_reset(3'd0, 1'b0);
    base = nv;
    run_stream(0, 23, 23, 24'h111111, 24'h222222, -1);
    chk(nv - base == 0, "R8 LJ short", 48'(nv - base), 48'd0);

    // R8: I2S halves of 24 bits are one short
    do_reset(3'd4, 1'b1);
    base = nv;
    run_stream(4, 24, 24, 24'h333333, 24'h444444, -1);
    chk(nv - base == 0, "R8 I2S short", 48'(nv - base), 48'd0);

    // R8: RJ with B halves of 23 bits drops both frames
    do_reset(3'd2, 1'b0);
    base = nv;
    run_stream(2, 32, 23, 24'h555555, 24'h666666, -1);
    chk(nv - base == 0, "R8 RJ short B", 48'(nv - base), 48'd0);

    // R10: first A half has no leading transition -> no pair
    do_reset(3'd2, 1'b1);
    base = nv;
    half(1'b1, 2, 24'h777777, 32, -1);
    half(1'b0, 2, 24'h888888, 32, -1);
    half(1'b1, 2, 24'h0, 32, -1);
    repeat (4) @(negedge clk);
    chk(nv - base == 0, "R10 unsynced", 48'(nv - base), 48'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule